// File: doc/BRIEF.md
# Rotating-Pattern Triplet Track Finder

This block searches for three-layer track candidates on concentric cylindrical detector layers. A single bank of bitwise coincidence logic serves every outer-hit angle. Before each event, a one-cycle clear empties two circular occupancy arrays, one per inner layer. The block then takes inner-layer hits one per clock, and each hit sets the bit that matches its azimuth bin.

During the search, outer-layer hits arrive one per clock over a valid/ready handshake. For each accepted outer hit, the block scales its azimuth by the fixed-point radius ratio of each inner layer to the outer layer. It uses the scaled value to rotate each inner array so that the relative-angle index is centred on bin 64. It then ANDs both rotated patterns with a programmable coincidence map. One cycle later, the resulting vector comes out together with the outer hit's azimuth, an any-bit match flag and a valid strobe. A downstream decoder turns that vector into track parameters.

Top module: `triplet_shift_finder`

## Requirements
- R1: After reset, `out_valid` is 0, `hit_ready` is 1, both inner arrays are empty and the coincidence map is all ones.
- R2: An inner write (`in_valid`=1) sets bit `in_phi` of the layer-1 array when `in_layer`=0, or of the layer-2 array when `in_layer`=1, from the next cycle on. The other bits are kept.
- R3: `clr`=1 zeroes both inner arrays from the next cycle on and takes priority over an inner write in the same cycle.
- R4: For outer azimuth p, the layer shift is s = floor((p*RATIO + 128)/256) mod 128. RATIO1 applies to layer 1 and RATIO2 to layer 2, each with 8 fractional bits.
- R5: The coincidence vector bit k equals C1[(k + s1 - 64) mod 128] AND C2[(k + s2 - 64) mod 128] AND map[k]. It uses the array and map contents of the acceptance cycle.
- R6: `out_match` equals the OR of all bits of `out_vec` for the same result.
- R7: `hit_ready` is 0 in any cycle with `clr` or `in_valid` high, and 1 otherwise. An outer hit is accepted when `hit_valid` and `hit_ready` are both 1.
- R8: Each accepted outer hit produces exactly one cycle of `out_valid` on the next cycle, with `out_idx` equal to its azimuth. `out_valid` is 0 in all other cycles.
- R9: `map_wr`=1 loads `map_data` into the coincidence map from the next cycle on. A hit accepted in the same cycle still uses the old map.
- R10: Index arithmetic wraps modulo 128, so outer azimuth 127 and inner bins near 0 still coincide correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr | input | 1 | Empty both inner arrays |
| in_valid | input | 1 | Inner hit write strobe |
| in_layer | input | 1 | 0 = layer 1, 1 = layer 2 |
| in_phi | input | 7 | Inner hit azimuth bin |
| map_wr | input | 1 | Coincidence map load strobe |
| map_data | input | 128 | New coincidence map |
| hit_valid | input | 1 | Outer hit offered |
| hit_phi | input | 7 | Outer hit azimuth bin |
| hit_ready | output | 1 | Outer hit can be taken this cycle |
| out_valid | output | 1 | Result strobe |
| out_idx | output | 7 | Azimuth of the outer hit for this result |
| out_vec | output | 128 | Coincidence vector to the decoder |
| out_match | output | 1 | Any bit of `out_vec` set |

## Verification
A stale or corrupt bit in an inner array or in the map only becomes visible on the port when it lands at a position that an outer hit rotates into coincidence. The bench therefore fills dense and sparse patterns and sweeps the outer azimuth over many values, including the wrap region, so that most array bins pass through the AND stage. An error in the shift scaling or in the rotation direction moves whole vectors. It shows on the first result after the hit is accepted, one clock later. A clear or write-priority fault shows on the first search after the next event boundary.

// File: rtl/tsf_pkg.sv
package tsf_pkg;
   typedef enum logic {LAYER_ONE = 1'b0, LAYER_TWO = 1'b1} layer_e;
endpackage

// File: rtl/tsf_scale.sv
module tsf_scale #(
   parameter int PHI_W = 7,
   parameter int FRAC  = 8,
   parameter int RATIO = 128
) (
   input  logic [PHI_W-1:0] phi_i,
   output logic [PHI_W-1:0] shift_o
);
   localparam int RW = FRAC + 1;
   localparam int PW = PHI_W + RW + 1;
   localparam logic [PW-1:0] HALF = PW'(1) << (FRAC - 1);

   if (RATIO < 0 || RATIO > (1 << FRAC)) begin : g_bad_ratio
      $error("tsf_scale: RATIO must lie in 0..1.0");
   end

   logic [PW-1:0] prod;
   assign prod    = PW'(phi_i) * PW'(RATIO) + HALF;
   assign shift_o = PHI_W'(prod >> FRAC);
endmodule

// File: rtl/tsf_rotate.sv
module tsf_rotate #(
   parameter int PHI_W = 7
) (
   input  logic [(1<<PHI_W)-1:0] pat_i,
   input  logic [PHI_W-1:0]      amt_i,
   output logic [(1<<PHI_W)-1:0] pat_o
);
   localparam int N = 1 << PHI_W;

   logic [N-1:0] stage [PHI_W+1];
   assign stage[0] = pat_i;

   for (genvar i = 0; i < PHI_W; i++) begin : g_stage
      localparam int SH = 1 << i;
      logic [N-1:0] rot;
      assign rot = (stage[i] >> SH) | (stage[i] << (N - SH));
      assign stage[i+1] = amt_i[i] ? rot : stage[i];
   end

   assign pat_o = stage[PHI_W];
endmodule

// File: rtl/triplet_shift_finder.sv
module triplet_shift_finder
   import tsf_pkg::*;
#(
   parameter int PHI_W  = 7,
   parameter int FRAC   = 8,
   parameter int RATIO1 = 43,
   parameter int RATIO2 = 171,
   parameter int BIAS   = 64,
   parameter logic [(1<<PHI_W)-1:0] MAP_INIT = '1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clr,
   input  logic                    in_valid,
   input  logic                    in_layer,
   input  logic [PHI_W-1:0]        in_phi,
   input  logic                    map_wr,
   input  logic [(1<<PHI_W)-1:0]   map_data,
   input  logic                    hit_valid,
   input  logic [PHI_W-1:0]        hit_phi,
   output logic                    hit_ready,
   output logic                    out_valid,
   output logic [PHI_W-1:0]        out_idx,
   output logic [(1<<PHI_W)-1:0]   out_vec,
   output logic                    out_match
);
   localparam int N = 1 << PHI_W;

   if (PHI_W < 2 || PHI_W > 10) begin : g_bad_width
      $error("triplet_shift_finder: PHI_W out of range");
   end
   if (BIAS < 0 || BIAS >= N) begin : g_bad_bias
      $error("triplet_shift_finder: BIAS must be below array size");
   end

   logic [N-1:0]     c1_q, c2_q, map_q;
   logic [PHI_W-1:0] s1, s2, amt1, amt2;
   logic [N-1:0]     r1, r2, vec;
   logic             accept;

   // inner arrays
   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         c1_q <= '0;
         c2_q <= '0;
      end else if (in_valid) begin
         if (layer_e'(in_layer) == LAYER_ONE) c1_q[in_phi] <= 1'b1;
         else                                 c2_q[in_phi] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      map_q <= MAP_INIT;
      else if (map_wr) map_q <= map_data;
   end

   tsf_scale #(.PHI_W(PHI_W), .FRAC(FRAC), .RATIO(RATIO1)) u_sc1 (.phi_i(hit_phi), .shift_o(s1));
   tsf_scale #(.PHI_W(PHI_W), .FRAC(FRAC), .RATIO(RATIO2)) u_sc2 (.phi_i(hit_phi), .shift_o(s2));

   assign amt1 = s1 - PHI_W'(BIAS);
   assign amt2 = s2 - PHI_W'(BIAS);

   tsf_rotate #(.PHI_W(PHI_W)) u_rot1 (.pat_i(c1_q), .amt_i(amt1), .pat_o(r1));
   tsf_rotate #(.PHI_W(PHI_W)) u_rot2 (.pat_i(c2_q), .amt_i(amt2), .pat_o(r2));

   assign vec       = r1 & r2 & map_q;
   assign hit_ready = !(clr || in_valid);
   assign accept    = hit_valid && hit_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_idx   <= '0;
         out_vec   <= '0;
         out_match <= 1'b0;
      end else begin
         out_valid <= accept;
         if (accept) begin
            out_idx   <= hit_phi;
            out_vec   <= vec;
            out_match <= |vec;
         end
      end
   end

   // R8: a result appears only one cycle after an accepted hit
   a_r8_result_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(hit_valid && hit_ready));

   // R8: result carries the accepted azimuth
   a_r8_index_echo: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_valid && hit_ready) |=> (out_idx == $past(hit_phi)));

   // R6: the match flag agrees with the vector it summarises
   a_r6_match_any: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_match == (out_vec != '0)));

   // R3: a hit searched right after a clear sees empty arrays
   a_r3_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_valid && hit_ready && $past(clr)) |=> (out_vec == '0));
endmodule

// File: tb/triplet_shift_finder_test.sv
`timescale 1ns/1ps
module triplet_shift_finder_test;
   localparam int N = 128;
   localparam int R1V = 43;
   localparam int R2V = 171;

   logic clk = 0;
   logic rst_n, clr, in_valid, in_layer, map_wr, hit_valid;
   logic [6:0] in_phi, hit_phi;
   logic [N-1:0] map_data;
   logic hit_ready, out_valid, out_match;
   logic [6:0] out_idx;
   logic [N-1:0] out_vec;

   int errors = 0, checks = 0;
   bit done = 0;
   bit m1 [N];
   bit m2 [N];
   bit mp [N];

   always #2.5 clk = ~clk;

   triplet_shift_finder uut (.*);

   task automatic chk(input bit ok, input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic int shf(input int p, input int r);
      return ((p * r + 128) / 256) % N;
   endfunction

   function automatic logic [N-1:0] model_vec(input int p);
      logic [N-1:0] v;
      int s1 = shf(p, R1V);
      int s2 = shf(p, R2V);
      for (int k = 0; k < N; k++) begin
         int j1 = (k + s1 - 64 + 2*N) % N;
         int j2 = (k + s2 - 64 + 2*N) % N;
         v[k] = m1[j1] & m2[j2] & mp[k];
      end
      return v;
   endfunction

   task automatic idle();
      clr = 0; in_valid = 0; in_layer = 0; in_phi = 0;
      map_wr = 0; map_data = '0; hit_valid = 0; hit_phi = 0;
   endtask

   // inputs already driven (after a negedge); model one clock and compare
   task automatic step();
      bit rdy, acc;
      logic [N-1:0] ev;
      #1;
      rdy = !(clr || in_valid);
      chk(hit_ready == rdy, "R7 ready", N'(hit_ready), N'(rdy));
      acc = hit_valid && rdy;
      ev = acc ? model_vec(int'(hit_phi)) : '0;
      if (clr) begin
         for (int i = 0; i < N; i++) begin m1[i] = 0; m2[i] = 0; end
      end else if (in_valid) begin
         if (in_layer) m2[in_phi] = 1; else m1[in_phi] = 1;
      end
      if (map_wr) for (int i = 0; i < N; i++) mp[i] = map_data[i];
      @(posedge clk);
      @(negedge clk);
      chk(out_valid == acc, "R8 valid", N'(out_valid), N'(acc));
      if (acc) begin
         chk(out_idx == hit_phi, "R8 index", N'(out_idx), N'(hit_phi));
         chk(out_vec == ev, "R5 vector", out_vec, ev);
         chk(out_match == (ev != '0), "R6 match", N'(out_match), N'(ev != '0));
      end
      idle();
   endtask

   task automatic wr(input bit lay, input int p);
      in_valid = 1; in_layer = lay; in_phi = 7'(p); step();
   endtask

   task automatic srch(input int p);
      hit_valid = 1; hit_phi = 7'(p); step();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      rst_n = 0; idle();
      for (int i = 0; i < N; i++) begin m1[i] = 0; m2[i] = 0; mp[i] = 1; end
      repeat (4) @(posedge clk);
      @(negedge clk); rst_n = 1;
      // R1: reset state
      chk(out_valid == 0, "R1 out_valid", N'(out_valid), '0);
      chk(hit_ready == 1, "R1 ready", N'(hit_ready), N'(1));
      srch(10);                       // R1 empty arrays -> zero vector
      chk(out_vec == '0, "R1 empty", out_vec, '0);
      // R2 dense fill, map all ones from reset (R1)
      for (int i = 0; i < N; i += 2) wr(0, i);
      for (int i = 0; i < N; i++) if (i % 3 != 0) wr(1, i);
      for (int p = 0; p < N; p += 5) srch(p);   // R4, R5 sweep
      srch(127); srch(126); srch(1);            // R10 wrap
      // R7: hit offered during write / clear not accepted
      hit_valid = 1; hit_phi = 7'd33; in_valid = 1; in_layer = 1; in_phi = 7'd0; step();
      hit_valid = 1; hit_phi = 7'd34; clr = 1; step();
      // R3: arrays empty after clear
      srch(50);
      // R3: clear wins over same-cycle write
      wr(0, 5);
      clr = 1; in_valid = 1; in_layer = 0; in_phi = 7'd9; step();
      srch(64);
      // sparse pattern aimed at a single coincidence (R5)
      wr(0, shf(100, R1V)); wr(1, shf(100, R2V));
      srch(100);
      chk(out_vec[64] == 1'b1, "R5 centred bin", N'(out_vec[64]), N'(1));
      // R9: map write with same-cycle hit uses old map
      map_wr = 1; map_data = '0; hit_valid = 1; hit_phi = 7'd100; step();
      chk(out_match == 1'b1, "R9 old map", N'(out_match), N'(1));
      srch(100);
      chk(out_match == 1'b0, "R9 new map", N'(out_match), '0);
      map_wr = 1; map_data = {64'h0, 64'hFFFF_FFFF_FFFF_FFFF} ^ {N{1'b1}} ^ 128'h5; step();
      for (int i = 0; i < N; i += 7) wr(0, i);
      for (int i = 0; i < N; i += 3) wr(1, i);
      for (int p = 0; p < N; p += 3) srch(p);
      // back-to-back hits
      hit_valid = 1; hit_phi = 7'd127; step();
      hit_valid = 1; hit_phi = 7'd0; step();
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule